// File: doc/BRIEF.md
# Accelerator Kernel Control Register File

This block is the host-facing register slave of a memory-to-memory accelerator kernel. A host on an AXI4-Lite bus programs three arguments: a 32-bit element count and two 64-bit buffer base addresses. It then launches the kernel by setting a start bit and polls a control/status word until the kernel reports completion. On the kernel side the block drives a level start signal and the argument values, and it takes a one-cycle done pulse back from the datapath.

The control/status word carries three flags. Start is set by the host and cleared by the block when the datapath finishes. Done is raised by completion and is cleared when the host reads the word. Idle is high whenever no job is running, drops once a launch is taken, and comes back in the same cycle as done. A host that polls for done therefore never sees done without idle. Each 64-bit address is held as two 32-bit words, with the low half at the lower offset.

Top module: `accel_ctl_regs`

## Requirements
- R1: After reset krn_start is 0, every argument output is 0, and the control word at 0x00 reads 0x4 (bit 0 start = 0, bit 1 done = 0, bit 2 idle = 1).
- R2: While idle, a write to 0x00 with data bit 0 set and byte strobe 0 set raises krn_start in the cycle the write response becomes valid. Idle is 0 from that same cycle, so the control word reads 0x1.
- R3: A one-cycle krn_done pulse clears krn_start on the next clock edge. On that same edge done and idle both become 1, so the control word reads 0x6.
- R4: A read of 0x00 returns the flags as they were when the read address was accepted, and clears done afterwards. A following read returns 0x4.
- R5: While a job runs (start set or idle low), writes to 0x00 leave krn_start unchanged, whatever the data.
- R6: The element count sits at 0x10. It drives krn_size and reads back.
- R7: The first pointer is held as a low word at 0x18 and a high word at 0x1C, and drives krn_ptr_a. The second pointer is held as a low word at 0x24 and a high word at 0x28, and drives krn_ptr_b.
- R8: A write updates only the bytes whose WSTRB bit is set (bit n covers data bits 8n+7..8n). The other bytes keep their old value.
- R9: Writes to unmapped or unaligned offsets change no register and get OKAY (2'b00). Reads of them return 0 with OKAY.
- R10: A write completes whether AW arrives before W, W before AW, or both arrive together.
- R11: Writes cannot set the done and idle bits. Writing 0x6 while idle leaves the control word at 0x4.
- R12: BVALID stays high until BREADY, and RVALID stays high with stable RDATA until RREADY. Every response is OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 6 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response (always OKAY) |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 6 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response (always OKAY) |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| krn_start | output | 1 | Level start to the datapath |
| krn_done | input | 1 | One-cycle completion pulse from the datapath |
| krn_size | output | 32 | Element count argument |
| krn_ptr_a | output | 64 | First buffer base address |
| krn_ptr_b | output | 64 | Second buffer base address |

## Verification
A write takes effect on the same clock edge that raises BVALID. The bench therefore waits for BVALID at a falling edge and checks krn_start, the argument outputs and the idle bit at that moment. Read data is registered on the edge that accepts the read address, so it is taken when RVALID is seen, one cycle after that handshake. A krn_done pulse driven for one cycle acts on the next rising edge, and the bench samples krn_start at the falling edge that follows. It then reads the control word twice, to see done set and then cleared.

// File: rtl/accel_ctl_pkg.sv
package accel_ctl_pkg;

    localparam int CSR_AW   = 6;
    localparam int CSR_DW   = 32;
    localparam int CSR_SW   = CSR_DW / 8;
    localparam int N_ARG    = 5;
    localparam int PTR_W    = 2 * CSR_DW;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    localparam int FLAG_START = 0;
    localparam int FLAG_DONE  = 1;
    localparam int FLAG_IDLE  = 2;

    // slot codes below N_ARG index the argument bank directly
    typedef enum logic [2:0] {
        SEL_SIZE  = 3'd0,
        SEL_PA_LO = 3'd1,
        SEL_PA_HI = 3'd2,
        SEL_PB_LO = 3'd3,
        SEL_PB_HI = 3'd4,
        SEL_CTRL  = 3'd5,
        SEL_NONE  = 3'd7
    } csr_sel_e;

    typedef struct packed {
        logic idle;
        logic done;
        logic start;
    } ctl_flags_t;

    typedef struct packed {
        logic [CSR_AW-1:0] addr;
        logic [CSR_DW-1:0] data;
        logic [CSR_SW-1:0] strb;
    } wr_req_t;

    function automatic csr_sel_e decode_addr(input logic [CSR_AW-1:0] a);
        csr_sel_e s;
        case (a)
            6'h00:   s = SEL_CTRL;
            6'h10:   s = SEL_SIZE;
            6'h18:   s = SEL_PA_LO;
            6'h1C:   s = SEL_PA_HI;
            6'h24:   s = SEL_PB_LO;
            6'h28:   s = SEL_PB_HI;
            default: s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic is_arg(input csr_sel_e s);
        return (32'(s) < N_ARG);
    endfunction

    function automatic logic [CSR_DW-1:0] merge_bytes(
        input logic [CSR_DW-1:0] old_w,
        input logic [CSR_DW-1:0] new_w,
        input logic [CSR_SW-1:0] strb
    );
        logic [CSR_DW-1:0] r;
        r = old_w;
        for (int b = 0; b < CSR_SW; b++) begin
            if (strb[b]) r[b*8 +: 8] = new_w[b*8 +: 8];
        end
        return r;
    endfunction

    function automatic logic [CSR_DW-1:0] flags_word(input ctl_flags_t f);
        logic [CSR_DW-1:0] w;
        w = '0;
        w[FLAG_START] = f.start;
        w[FLAG_DONE]  = f.done;
        w[FLAG_IDLE]  = f.idle;
        return w;
    endfunction

endpackage

// File: rtl/accel_ctl_wr_if.sv
module accel_ctl_wr_if
    import accel_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] awaddr,
    input  logic              awvalid,
    output logic              awready,
    input  logic [CSR_DW-1:0] wdata,
    input  logic [CSR_SW-1:0] wstrb,
    input  logic              wvalid,
    output logic              wready,
    output logic [1:0]        bresp,
    output logic              bvalid,
    input  logic              bready,
    output logic              wr_fire,
    output wr_req_t           wr_req
);

    logic    aw_full, w_full, bvalid_q;
    wr_req_t req_q;

    assign awready = !aw_full && !bvalid_q;
    assign wready  = !w_full  && !bvalid_q;
    assign wr_fire = aw_full && w_full && !bvalid_q;
    assign wr_req  = req_q;
    assign bvalid  = bvalid_q;
    assign bresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            aw_full  <= 1'b0;
            w_full   <= 1'b0;
            bvalid_q <= 1'b0;
            req_q    <= '0;
        end else begin
            if (awvalid && awready) begin
                aw_full    <= 1'b1;
                req_q.addr <= awaddr;
            end
            if (wvalid && wready) begin
                w_full     <= 1'b1;
                req_q.data <= wdata;
                req_q.strb <= wstrb;
            end
            if (wr_fire) begin
                aw_full  <= 1'b0;
                w_full   <= 1'b0;
                bvalid_q <= 1'b1;
            end else if (bvalid_q && bready) begin
                bvalid_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/accel_ctl_rd_if.sv
module accel_ctl_rd_if
    import accel_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              arvalid,
    output logic              arready,
    output logic [CSR_DW-1:0] rdata,
    output logic [1:0]        rresp,
    output logic              rvalid,
    input  logic              rready,
    input  logic [CSR_DW-1:0] rd_word,
    output logic              rd_fire
);

    logic              rvalid_q;
    logic [CSR_DW-1:0] rdata_q;

    assign arready = !rvalid_q;
    assign rd_fire = arvalid && arready;
    assign rvalid  = rvalid_q;
    assign rdata   = rdata_q;
    assign rresp   = RESP_OKAY;

    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else if (rd_fire) begin
            rvalid_q <= 1'b1;
            rdata_q  <= rd_word;
        end else if (rvalid_q && rready) begin
            rvalid_q <= 1'b0;
        end
    end

endmodule

// File: rtl/accel_ctl_status.sv
module accel_ctl_status
    import accel_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       launch_req,
    input  logic       flags_read,
    input  logic       krn_done,
    output ctl_flags_t flags
);

    ctl_flags_t f_q;
    logic       busy;

    assign busy  = f_q.start || !f_q.idle;
    assign flags = f_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q.start <= 1'b0;
            f_q.done  <= 1'b0;
            f_q.idle  <= 1'b1;
        end else begin
            if (krn_done) begin
                f_q.start <= 1'b0;
                f_q.idle  <= 1'b1;
            end else if (launch_req && !busy) begin
                f_q.start <= 1'b1;
                f_q.idle  <= 1'b0;
            end
            if (krn_done) begin
                f_q.done <= 1'b1;
            end else if (flags_read) begin
                f_q.done <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/accel_ctl_args.sv
module accel_ctl_args
    import accel_ctl_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         we,
    input  csr_sel_e                     sel,
    input  logic [CSR_DW-1:0]            data,
    input  logic [CSR_SW-1:0]            strb,
    output logic [N_ARG-1:0][CSR_DW-1:0] words
);

    for (genvar g = 0; g < N_ARG; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (we && (32'(sel) == g)) begin
                words[g] <= merge_bytes(words[g], data, strb);
            end
        end
    end

endmodule

// File: rtl/accel_ctl_regs.sv
module accel_ctl_regs
    import accel_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CSR_AW-1:0] s_awaddr,
    input  logic              s_awvalid,
    output logic              s_awready,
    input  logic [CSR_DW-1:0] s_wdata,
    input  logic [CSR_SW-1:0] s_wstrb,
    input  logic              s_wvalid,
    output logic              s_wready,
    output logic [1:0]        s_bresp,
    output logic              s_bvalid,
    input  logic              s_bready,
    input  logic [CSR_AW-1:0] s_araddr,
    input  logic              s_arvalid,
    output logic              s_arready,
    output logic [CSR_DW-1:0] s_rdata,
    output logic [1:0]        s_rresp,
    output logic              s_rvalid,
    input  logic              s_rready,
    output logic              krn_start,
    input  logic              krn_done,
    output logic [CSR_DW-1:0] krn_size,
    output logic [PTR_W-1:0]  krn_ptr_a,
    output logic [PTR_W-1:0]  krn_ptr_b
);

    logic                         wr_fire, rd_fire;
    wr_req_t                      wr_req;
    csr_sel_e                     wr_sel, rd_sel;
    ctl_flags_t                   flags;
    logic [N_ARG-1:0][CSR_DW-1:0] arg_words;
    logic [CSR_DW-1:0]            rd_word;
    logic                         launch_req, flags_read;
    logic                         stat_idle, stat_done;

    assign wr_sel = decode_addr(wr_req.addr);
    assign rd_sel = decode_addr(s_araddr);

    accel_ctl_wr_if wr_i (
        .clk(clk), .rst(rst),
        .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
        .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
        .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
        .wr_fire(wr_fire), .wr_req(wr_req)
    );

    accel_ctl_rd_if rd_i (
        .clk(clk), .rst(rst),
        .arvalid(s_arvalid), .arready(s_arready),
        .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
        .rd_word(rd_word), .rd_fire(rd_fire)
    );

    assign launch_req = wr_fire && (wr_sel == SEL_CTRL)
                        && wr_req.strb[0] && wr_req.data[FLAG_START];
    assign flags_read = rd_fire && (rd_sel == SEL_CTRL);

    accel_ctl_status st_i (
        .clk(clk), .rst(rst),
        .launch_req(launch_req), .flags_read(flags_read),
        .krn_done(krn_done), .flags(flags)
    );

    accel_ctl_args args_i (
        .clk(clk), .rst(rst),
        .we(wr_fire && is_arg(wr_sel)), .sel(wr_sel),
        .data(wr_req.data), .strb(wr_req.strb),
        .words(arg_words)
    );

    always_comb begin
        rd_word = '0;
        if (rd_sel == SEL_CTRL) begin
            rd_word = flags_word(flags);
        end else if (is_arg(rd_sel)) begin
            rd_word = arg_words[rd_sel];
        end
    end

    assign krn_start = flags.start;
    assign krn_size  = arg_words[SEL_SIZE];
    assign krn_ptr_a = {arg_words[SEL_PA_HI], arg_words[SEL_PA_LO]};
    assign krn_ptr_b = {arg_words[SEL_PB_HI], arg_words[SEL_PB_LO]};
    assign stat_idle = flags.idle;
    assign stat_done = flags.done;

endmodule

// File: rtl/accel_ctl_regs_chk.sv
module accel_ctl_regs_chk (
    input logic        clk,
    input logic        rst,
    input logic        s_bvalid,
    input logic        s_bready,
    input logic [1:0]  s_bresp,
    input logic        s_rvalid,
    input logic        s_rready,
    input logic [31:0] s_rdata,
    input logic [1:0]  s_rresp,
    input logic        krn_start,
    input logic        krn_done,
    input logic        stat_idle,
    input logic        stat_done
);

    // R12
    bresp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_bvalid && !s_bready |=> s_bvalid);

    // R12
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));

    // R12
    resp_okay_chk: assert property (@(posedge clk) disable iff (rst)
        (s_bvalid |-> s_bresp == 2'b00) and (s_rvalid |-> s_rresp == 2'b00));

    // R3
    done_clears_start_chk: assert property (@(posedge clk) disable iff (rst)
        krn_done |=> !krn_start && stat_done && stat_idle);

    // R3
    idle_rise_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(stat_idle) |-> stat_done);

    // R2
    idle_fall_on_launch_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat_idle) |-> krn_start);

    // R5
    start_holds_chk: assert property (@(posedge clk) disable iff (rst)
        krn_start && !krn_done |=> krn_start);

endmodule

bind accel_ctl_regs accel_ctl_regs_chk chk_i (
    .clk(clk), .rst(rst),
    .s_bvalid(s_bvalid), .s_bready(s_bready), .s_bresp(s_bresp),
    .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata), .s_rresp(s_rresp),
    .krn_start(krn_start), .krn_done(krn_done),
    .stat_idle(stat_idle), .stat_done(stat_done)
);

// File: tb/accel_ctl_regs_tb_top.sv
`timescale 1ns/1ps
module accel_ctl_regs_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  awaddr = '0;
    logic        awvalid = 1'b0;
    logic        awready;
    logic [31:0] wdata = '0;
    logic [3:0]  wstrb = '0;
    logic        wvalid = 1'b0;
    logic        wready;
    logic [1:0]  bresp;
    logic        bvalid;
    logic        bready = 1'b0;
    logic [5:0]  araddr = '0;
    logic        arvalid = 1'b0;
    logic        arready;
    logic [31:0] rdata;
    logic [1:0]  rresp;
    logic        rvalid;
    logic        rready = 1'b0;
    logic        krn_start;
    logic        krn_done = 1'b0;
    logic [31:0] krn_size;
    logic [63:0] krn_ptr_a;
    logic [63:0] krn_ptr_b;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    accel_ctl_regs dut_i (
        .clk(clk), .rst(rst),
        .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
        .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
        .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
        .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
        .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
        .krn_start(krn_start), .krn_done(krn_done),
        .krn_size(krn_size), .krn_ptr_a(krn_ptr_a), .krn_ptr_b(krn_ptr_b)
    );

    typedef struct packed {
        logic [5:0]  a;
        logic [31:0] d;
        logic [3:0]  s;
        logic [1:0]  ord;   // 0 together, 1 AW first, 2 W first
        logic [31:0] exp_rd;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VEC [NVEC] = '{
        '{6'h10, 32'h0000_0040, 4'hF, 2'd0, 32'h0000_0040},
        '{6'h18, 32'h1000_0000, 4'hF, 2'd1, 32'h1000_0000},
        '{6'h1C, 32'h0000_0001, 4'hF, 2'd2, 32'h0000_0001},
        '{6'h24, 32'h2000_0000, 4'hF, 2'd0, 32'h2000_0000},
        '{6'h28, 32'h0000_0002, 4'hF, 2'd1, 32'h0000_0002},
        '{6'h10, 32'hAABB_CCDD, 4'b0101, 2'd2, 32'h00BB_00DD},
        '{6'h18, 32'hFFFF_FFFF, 4'b1000, 2'd0, 32'hFF00_0000},
        '{6'h14, 32'hDEAD_BEEF, 4'hF, 2'd1, 32'h0000_0000},
        '{6'h20, 32'h0000_1234, 4'hF, 2'd2, 32'h0000_0000},
        '{6'h2E, 32'h5555_5555, 4'hF, 2'd0, 32'h0000_0000}
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic axi_wr(input logic [5:0] a, input logic [31:0] d, input logic [3:0] s,
                          input logic [1:0] ord, output logic [1:0] resp);
        bit aw_ok, w_ok, hs_aw, hs_w;
        aw_ok = 0;
        w_ok  = 0;
        @(negedge clk);
        if (ord != 2'd2) begin awaddr = a; awvalid = 1'b1; end
        if (ord != 2'd1) begin wdata = d; wstrb = s; wvalid = 1'b1; end
        while (!(aw_ok && w_ok)) begin
            hs_aw = awvalid && awready;
            hs_w  = wvalid && wready;
            @(negedge clk);
            if (hs_aw) begin awvalid = 1'b0; aw_ok = 1; end
            if (hs_w)  begin wvalid  = 1'b0; w_ok  = 1; end
            if (aw_ok && !w_ok && !wvalid) begin wdata = d; wstrb = s; wvalid = 1'b1; end
            if (w_ok && !aw_ok && !awvalid) begin awaddr = a; awvalid = 1'b1; end
        end
        while (!bvalid) @(negedge clk);
        resp   = bresp;
        bready = 1'b1;
        @(negedge clk);
        bready = 1'b0;
    endtask

    task automatic axi_rd(input logic [5:0] a, output logic [31:0] d, output logic [1:0] resp);
        @(negedge clk);
        araddr  = a;
        arvalid = 1'b1;
        while (!arready) @(negedge clk);
        @(negedge clk);
        arvalid = 1'b0;
        while (!rvalid) @(negedge clk);
        d      = rdata;
        resp   = rresp;
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        krn_done = 1'b1;
        @(negedge clk);
        krn_done = 1'b0;
    endtask

    initial begin
        #500000;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] rd;
        logic [1:0]  rsp;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 krn_start", 64'(krn_start), 64'd0);
        check("R1 krn_size", 64'(krn_size), 64'd0);
        check("R1 krn_ptr_a", krn_ptr_a, 64'd0);
        check("R1 krn_ptr_b", krn_ptr_b, 64'd0);
        check("R12 bvalid idle", 64'(bvalid), 64'd0);
        axi_rd(6'h00, rd, rsp);
        check("R1 ctrl word", 64'(rd), 64'h4);

        // R6 R7 R8 R9 R10: table walk
        for (int i = 0; i < NVEC; i++) begin
            axi_wr(VEC[i].a, VEC[i].d, VEC[i].s, VEC[i].ord, rsp);
            check("R12 bresp okay", 64'(rsp), 64'd0);
            axi_rd(VEC[i].a, rd, rsp);
            check("R10 R8 R9 readback", 64'(rd), 64'(VEC[i].exp_rd));
            check("R9 rresp okay", 64'(rsp), 64'd0);
        end
        check("R6 krn_size", 64'(krn_size), 64'h00BB_00DD);
        check("R7 krn_ptr_a", krn_ptr_a, 64'h0000_0001_FF00_0000);
        check("R7 krn_ptr_b", krn_ptr_b, 64'h0000_0002_2000_0000);
        axi_rd(6'h3C, rd, rsp);
        check("R9 unmapped read", 64'(rd), 64'd0);

        // R11 done and idle bits not writable
        axi_wr(6'h00, 32'h6, 4'hF, 2'd0, rsp);
        check("R11 start after 0x6", 64'(krn_start), 64'd0);
        axi_rd(6'h00, rd, rsp);
        check("R11 ctrl after 0x6", 64'(rd), 64'h4);

        // R8 start ignored when strobe 0 is clear
        axi_wr(6'h00, 32'h1, 4'b1110, 2'd0, rsp);
        check("R8 start masked", 64'(krn_start), 64'd0);

        // R2 launch
        axi_wr(6'h00, 32'h1, 4'h1, 2'd1, rsp);
        check("R2 krn_start", 64'(krn_start), 64'd1);
        axi_rd(6'h00, rd, rsp);
        check("R2 ctrl busy", 64'(rd), 64'h1);

        // R5 writes while busy
        axi_wr(6'h00, 32'h0, 4'hF, 2'd0, rsp);
        check("R5 start kept after 0", 64'(krn_start), 64'd1);
        axi_wr(6'h00, 32'h7, 4'hF, 2'd2, rsp);
        axi_rd(6'h00, rd, rsp);
        check("R5 ctrl busy", 64'(rd), 64'h1);

        // R3 completion
        pulse_done();
        check("R3 start cleared", 64'(krn_start), 64'd0);
        // R4 read clears done
        axi_rd(6'h00, rd, rsp);
        check("R3 R4 ctrl done", 64'(rd), 64'h6);
        axi_rd(6'h00, rd, rsp);
        check("R4 ctrl cleared", 64'(rd), 64'h4);

        // R2 relaunch, R4 done stays until read
        axi_wr(6'h00, 32'h1, 4'hF, 2'd0, rsp);
        check("R2 relaunch", 64'(krn_start), 64'd1);
        pulse_done();
        axi_rd(6'h10, rd, rsp);
        check("R4 size read leaves done", 64'(rd), 64'h00BB_00DD);
        axi_rd(6'h00, rd, rsp);
        check("R4 done held", 64'(rd), 64'h6);

        // R12 held responses under backpressure
        @(negedge clk);
        araddr = 6'h28; arvalid = 1'b1;
        @(negedge clk);
        arvalid = 1'b0;
        repeat (3) @(negedge clk);
        check("R12 rvalid held", 64'(rvalid), 64'd1);
        check("R12 rdata held", 64'(rdata), 64'h2);
        rready = 1'b1;
        @(negedge clk);
        rready = 1'b0;
        check("R12 rvalid dropped", 64'(rvalid), 64'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule